// File: doc/BRIEF.md
# Multi-Channel Prescaled PWM Generator

This block produces a set of pulse-width-modulated outputs that all run from one shared 8-bit period counter. The counter always covers 256 counts. The only control over period length is a 4-bit clock divider that sets how many input clocks make up one count. Each channel has its own compare value, and that value sets how long the channel's output stays high at the start of every period. The duty encoding is offset by one, so an enabled channel is never fully low.

Software drives the block through a 32-bit register interface with word addresses. The interface holds one compare register per channel, a control register that carries the divider setting and a global run bit, an interrupt-enable register, and a read-only copy of the live counter. Compare writes land in a holding copy. The holding copy moves into the active comparator only when the counter wraps, so a period never sees a pulse width change partway through. When enabled, an interrupt line pulses once at the start of each new period.

Top module: `pwm_bank`

## Requirements
- R1: While running, the period counter advances by exactly one per local tick, from 0 up to 255, and then returns to 0.
- R2: A local tick lasts (P + 1) input clocks, where P is control bits [3:0]. A full period therefore lasts 256 × (P + 1) input clocks.
- R3: A channel with active compare value N drives its output high while the counter is at most N. This gives (N + 1) × (P + 1) high clocks per period. N = 255 keeps the output high for the whole period.
- R4: Channel k's compare register is at byte address 4 × k. It stores the low 8 bits of the written data and reads back with bits [31:8] as zero.
- R5: The control register is at address 0x50, with the divider in bits [3:0] and the run bit in bit 9. It reads back only those bits, and every other bit reads as zero.
- R6: While the run bit is 0, the divider and the counter are held at zero and every output is low.
- R7: Bit 0 of the register at address 0x54 enables the interrupt. When it is 1, the interrupt output is high for exactly one input clock per period: the first clock in which the counter shows 0 after a wrap. When it is 0, the interrupt output stays low.
- R8: Address 0x58 returns the live counter value in bits [7:0]. Writes to address 0x58 have no effect.
- R9: A compare write made while running takes effect at the next wrap from 255 to 0. The period in progress keeps its old width. While the run bit is 0, a written value reaches the comparator within one clock.
- R10: Read data is combinational. It is valid in the same clock in which read enable is high, and it is zero while read enable is low. Addresses that decode to nothing, including compare slots beyond the channel count, read as zero and ignore writes.
- R11: The channel count is a parameter from 1 to 16. The compare slots always stay below address 0x50.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 32 | Read data, valid while bus_re is high |
| pwm_out | output | NCH | One PWM output per channel |
| irq | output | 1 | One-clock period-start interrupt pulse |

## Verification
The assertions check, on every cycle, that the counter only steps by one and that the outputs stay low while stopped. They also check that a full-scale compare keeps its output high, that the active compare value only changes at a wrap or while stopped, and that the interrupt appears for a single clock with the counter at zero. Only the bench scenarios can show the exact high time and period length for each divider setting. The same applies to the one-period delay before a mid-period compare write takes effect, the register read-back encodings, and that writes to unused or read-only addresses have no effect.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int CNT_W   = 8;
  localparam int PRE_W   = 4;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 8;
  localparam int RUN_BIT = 9;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 8'h50;
  localparam logic [ADDR_W-1:0] IEN_ADDR  = 8'h54;
  localparam logic [ADDR_W-1:0] CNT_ADDR  = 8'h58;
endpackage

// File: rtl/pwm_bank_timebase.sv
module pwm_bank_timebase
  import pwm_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [PRE_W-1:0] div_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o
);
  logic [PRE_W-1:0] div_q, div_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tick;

  // >= keeps the divider from running away if the setting shrinks mid-tick
  assign tick   = (div_q >= div_i);
  assign wrap_o = run_i && tick && (cnt_q == {CNT_W{1'b1}});
  assign count_o = cnt_q;

  always_comb begin
    div_d = div_q;
    cnt_d = cnt_q;
    if (!run_i) begin
      div_d = '0;
      cnt_d = '0;
    end else if (tick) begin
      div_d = '0;
      cnt_d = cnt_q + 1'b1;
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else begin
      div_q <= div_d;
      cnt_q <= cnt_d;
    end
  end

  // R1: counter moves by at most one step per clock
  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));

  // R6: stopped means counter parked at zero one clock later
  p_stop_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && $past(!run_i)) |-> (cnt_q == '0));
endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
  import pwm_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             wrap_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] shadow_o,
  output logic             pwm_o
);
  logic [CNT_W-1:0] shadow_q, shadow_d;
  logic [CNT_W-1:0] active_q, active_d;
  logic             load_active;

  assign load_active = !run_i || wrap_i;

  always_comb begin
    shadow_d = shadow_q;
    active_d = active_q;
    if (wr_i)        shadow_d = wdata_i;
    if (load_active) active_d = shadow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      shadow_q <= shadow_d;
      active_q <= active_d;
    end
  end

  assign shadow_o = shadow_q;
  assign pwm_o    = run_i && (count_i <= active_q);

  // R9: comparator value only moves at a wrap or while stopped
  p_active_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !wrap_i) |=> $stable(active_q));

  // R3: full-scale compare never lets the output drop while running
  p_full_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && active_q == {CNT_W{1'b1}}) |-> pwm_o);
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    pwm_out,
  output logic              irq
);
  localparam int LAST_SLOT = 4 * (NCH - 1);

  initial begin
    assert (NCH >= 1 && NCH <= 16 && LAST_SLOT < int'(CTRL_ADDR))
      else $error("R11: channel count out of range");
  end

  logic [PRE_W-1:0] div_q, div_d;
  logic             run_q, run_d;
  logic             ien_q, ien_d;
  logic             irq_q, irq_d;
  logic [CNT_W-1:0] count;
  logic             wrap;
  logic [CNT_W-1:0] shadow [NCH];
  logic [NCH-1:0]   ch_wr;

  pwm_bank_timebase u_timebase (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (run_q),
    .div_i   (div_q),
    .count_o (count),
    .wrap_o  (wrap)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    assign ch_wr[g] = bus_we && (bus_addr == ADDR_W'(4 * g));
    pwm_bank_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (run_q),
      .wrap_i   (wrap),
      .count_i  (count),
      .wr_i     (ch_wr[g]),
      .wdata_i  (bus_wdata[CNT_W-1:0]),
      .shadow_o (shadow[g]),
      .pwm_o    (pwm_out[g])
    );
  end

  always_comb begin
    div_d = div_q;
    run_d = run_q;
    ien_d = ien_q;
    if (bus_we && bus_addr == CTRL_ADDR) begin
      div_d = bus_wdata[PRE_W-1:0];
      run_d = bus_wdata[RUN_BIT];
    end
    if (bus_we && bus_addr == IEN_ADDR) ien_d = bus_wdata[0];
    irq_d = ien_q && wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      run_q <= 1'b0;
      ien_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      div_q <= div_d;
      run_q <= run_d;
      ien_q <= ien_d;
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      if (bus_addr == CTRL_ADDR) begin
        bus_rdata[PRE_W-1:0] = div_q;
        bus_rdata[RUN_BIT]   = run_q;
      end
      if (bus_addr == IEN_ADDR) bus_rdata[0] = ien_q;
      if (bus_addr == CNT_ADDR) bus_rdata[CNT_W-1:0] = count;
      for (int i = 0; i < NCH; i++) begin
        if (bus_addr == ADDR_W'(4 * i)) bus_rdata[CNT_W-1:0] = shadow[i];
      end
    end
  end

  // R6: nothing drives high while stopped
  p_off_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (pwm_out == '0));

  // R7: interrupt is a single-clock pulse
  p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R7: interrupt coincides with the counter showing zero
  p_irq_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (count == '0));

  // R10: idle read port returns zero
  p_idle_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |-> (bus_rdata == '0));
endmodule

// File: tb/pwm_bank_bench.sv
module pwm_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we;
  logic        bus_re;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] pwm_out;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int hi_cnt [NCH];
  int irq_cnt;
  bit done = 0;

  pwm_bank #(.NCH(NCH)) u_pwm_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int exp_high(int n, int p);
    return (n + 1) * (p + 1);
  endfunction

  function automatic int exp_period(int p);
    return 256 * (p + 1);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    bus_re = 1'b0;
  endtask

  task automatic wait_irq();
    int guard = 0;
    while (!irq && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    chk(irq, "R7 irq arrival", irq, 1);
  endtask

  // Count high clocks per channel over one period starting at an irq sample
  task automatic measure(int p, bit do_wr, logic [7:0] wa, logic [31:0] wd);
    irq_cnt = 0;
    for (int c = 0; c < NCH; c++) hi_cnt[c] = 0;
    for (int i = 0; i < exp_period(p); i++) begin
      if (irq) irq_cnt++;
      for (int c = 0; c < NCH; c++) hi_cnt[c] += int'(pwm_out[c]);
      if (do_wr && i == 20) begin
        bus_addr = wa; bus_wdata = wd; bus_we = 1'b1;
      end
      if (do_wr && i == 21) bus_we = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic run_and_check(int p, int cmp [NCH]);
    wr(8'h50, 32'h0);
    for (int c = 0; c < NCH; c++) wr(8'(4 * c), 32'(cmp[c]));
    wr(8'h54, 32'h1);
    wr(8'h50, (32'h1 << 9) | 32'(p));
    wait_irq();
    measure(p, 1'b0, 8'h0, 32'h0);
    for (int c = 0; c < NCH; c++)
      chk(hi_cnt[c] == exp_high(cmp[c], p), "R3 high time", hi_cnt[c], exp_high(cmp[c], p));
    chk(irq_cnt == 1, "R7 one irq per period", irq_cnt, 1);
    chk(irq == 1'b1, "R2 period length", irq, 1);
  endtask

  initial begin
    logic [31:0] d;
    int cmp [NCH];
    int p;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; bus_re = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    chk(pwm_out == '0, "R6 reset outputs", int'(pwm_out), 0);
    chk(irq == 1'b0, "R7 reset irq", irq, 0);
    rd(8'h50, d); chk(d == 0, "R5 reset ctrl", d, 0);
    rd(8'h58, d); chk(d == 0, "R8 reset count", d, 0);

    // R4 compare register read-back, upper bits dropped
    for (int c = 0; c < NCH; c++) begin
      wr(8'(4 * c), 32'hABCD_EF00 | 32'(c * 17 + 5));
      rd(8'(4 * c), d);
      chk(d == 32'(c * 17 + 5), "R4 compare readback", d, c * 17 + 5);
    end

    // R10 unused and absent slots
    wr(8'h10, 32'hFF);
    rd(8'h10, d); chk(d == 0, "R10 absent channel slot", d, 0);
    wr(8'h60, 32'hFFFF_FFFF);
    rd(8'h60, d); chk(d == 0, "R10 unused address", d, 0);
    rd(8'h00, d); chk(d == 32'd5, "R10 unused write harmless", d, 5);
    @(negedge clk); bus_addr = 8'h00; bus_re = 1'b0;
    #1 chk(bus_rdata == 0, "R10 idle read zero", bus_rdata, 0);

    // R8 count register ignores writes
    wr(8'h58, 32'hFF);
    rd(8'h58, d); chk(d == 0, "R8 count read-only", d, 0);

    // R5 control readback, run bit clear
    wr(8'h50, 32'hFFFF_FDFF);
    rd(8'h50, d); chk(d == 32'hF, "R5 ctrl bits", d, 15);
    repeat (40) @(negedge clk);
    chk(pwm_out == '0, "R6 stopped outputs", int'(pwm_out), 0);
    rd(8'h58, d); chk(d == 0, "R6 stopped counter", d, 0);
    wr(8'h54, 32'hFFFF_FFFF);
    rd(8'h54, d); chk(d == 1, "R7 irq enable readback", d, 1);

    // directed corners: 0, 255 and mid values
    cmp = '{0, 255, 127, 3};
    run_and_check(0, cmp);
    rd(8'h50, d); chk(d == 32'h200, "R5 running ctrl", d, 32'h200);

    // R1 counter read-back at known offset from period start, divider 2
    run_and_check(2, cmp);
    repeat (37) @(negedge clk);
    bus_addr = 8'h58; bus_re = 1'b1;
    #1 chk(bus_rdata == 32'(37 / 3), "R1 live count", bus_rdata, 37 / 3);
    bus_re = 1'b0;

    // R9 shadow: mid-period write takes effect next period
    wait_irq();
    measure(2, 1'b1, 8'h08, 32'd40);
    chk(hi_cnt[2] == exp_high(127, 2), "R9 old width kept", hi_cnt[2], exp_high(127, 2));
    measure(2, 1'b0, 8'h0, 32'h0);
    chk(hi_cnt[2] == exp_high(40, 2), "R9 new width applied", hi_cnt[2], exp_high(40, 2));

    // R7 interrupt disabled
    wr(8'h54, 32'h0);
    irq_cnt = 0;
    for (int i = 0; i < 2 * exp_period(2); i++) begin
      if (irq) irq_cnt++;
      @(negedge clk);
    end
    chk(irq_cnt == 0, "R7 masked irq", irq_cnt, 0);

    // random patterns
    for (int t = 0; t < 6; t++) begin
      p = int'($urandom_range(0, 3));
      for (int c = 0; c < NCH; c++) cmp[c] = int'($urandom_range(0, 255));
      run_and_check(p, cmp);
    end

    // R6 stopping returns everything low
    wr(8'h50, 32'h0);
    @(negedge clk);
    for (int i = 0; i < 300; i++) begin
      if (pwm_out != '0) chk(1'b0, "R6 output after stop", int'(pwm_out), 0);
      @(negedge clk);
    end
    chk(pwm_out == '0, "R6 output after stop", int'(pwm_out), 0);
    rd(8'h58, d); chk(d == 0, "R6 counter after stop", d, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule